// File: doc/BRIEF.md
# Reconfigurable Word-Level Processing Cell

This block is one processing cell of a coarse-grained compute array. On every enabled clock cycle it performs one configured operation, either an 8-bit or a 16-bit operation and either signed or unsigned, on two or three operands. Each operand is picked from one of four sources: the input stream word, a global register word, the result of a cell in the neighbouring row, or the cell's own local register. The result is captured in an output register.

The cell's configuration sits in two register layers. One layer is active and drives execution. The other is written through a narrow configuration port while the active one keeps running. A swap pulse exchanges the two roles, and the enabled cycle right after the swap already executes with the new layer, so a reconfiguration costs no cycle. The local register works either as a one-cycle delay of the first operand or as a constant coefficient held in the layer.

The data inputs carry no valid/ready handshake. The `en` pin is the only flow control: when it is low the cell stalls and keeps both outputs unchanged, so an upstream stall is passed on by holding `en` low. No data is ever dropped or buffered inside the cell. Configuration writes and swaps do not depend on `en`.

Top module: `pcell_top`

## Requirements
- R1: During and after an active-low reset, both outputs read 0 and layer 0 is active with all fields zero. That zero configuration means ADD, 8-bit, unsigned, with every operand taken from the stream.
- R2: A write (`cfg_en`=1) always lands in the inactive layer. Execution keeps using the active layer unchanged until a swap. The addresses are 0 for the control word, 1 for the coefficient, and 2 for the routing word; address 3 has no effect.
- R3: `cfg_swap`=1 toggles the active layer at that clock edge, and the next enabled cycle computes with the new layer. A write issued in the same cycle as a swap lands in the layer that becomes active.
- R4: While `en`=0, `pe_out` and `lor_out` hold their values.
- R5: The control-word fields are: op in bits [3:0], wide in bit [4], sgn in bit [5], the source of A in [7:6], the source of B in [9:8], the source of C in [11:10], and the shift amount in [15:12]. The source codes are 0 for stream, 1 for global register, 2 for neighbour and 3 for local register. Op 14 passes A through unchanged.
- R6: The logic and add opcodes are 0 for A+B, 1 for A-B, 2 for AND, 3 for OR, 4 for XOR and 11 for A+B+C. All of them wrap modulo 2^width. Op 15 gives 0.
- R7: Op 5 gives A*B and op 6 gives A*B+C, each as the low `width` bits.
- R8: Op 7 shifts A left by the shift amount. Op 8 shifts A right by the shift amount, filling with the sign bit when sgn=1 and with zeros otherwise.
- R9: Op 9 adds 2^(shift-1) to A and then shifts right as op 8 does. With a shift of 0 it returns A.
- R10: Op 10 gives |A-B|, op 12 gives min(A,B) and op 13 gives max(A,B). All three compare signed when sgn=1 and unsigned otherwise.
- R11: With wide=0, each operand uses its low 8 bits, sign-extended if sgn=1 and zero-extended otherwise. The 8-bit result is extended to 16 bits in the same way.
- R12: Routing-word bit 1 selects the local-register mode. When it is 1, the local register loads the active coefficient on each enabled cycle. When it is 0, it loads operand A.
- R13: Routing-word bit 0 makes the output register capture the local register's previous value instead of the ALU result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Execute enable; low stalls the cell |
| cfg_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word address |
| cfg_data | input | 16 | Configuration write data |
| cfg_swap | input | 1 | Exchange active and shadow layers |
| strm_in | input | 16 | Input stream operand |
| greg_in | input | 16 | Global register operand |
| nbr_in | input | 16 | Neighbour-row result operand |
| pe_out | output | 16 | Registered cell result |
| lor_out | output | 16 | Local register value |

## Verification
On every cycle, the assertions check that a stalled cell holds its outputs and that the layer select flips exactly on a swap. They also check that a write without a swap leaves the active layer untouched, that coefficient mode and output forwarding move the right words, and that narrow results are correctly extended. The arithmetic of each opcode in each width and signedness can only be shown by the bench's scenarios. The same holds for the rounding offset, operand routing, and the fact that the first cycle after a swap computes with the new layer. For these, the bench compares every cycle against its behavioural model, driving boundary operands such as 0x8000, 0x7FFF, 0x80 and 0xFFFF.

// File: rtl/pcell_pkg.sv
package pcell_pkg;
  localparam int CFG_W      = 16;
  localparam int CFG_ADDR_W = 2;
  localparam int SRC_W      = 2;
  localparam int SH_W       = 4;
  localparam int N_OPND     = 3;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,  OP_SUB  = 4'd1,  OP_AND  = 4'd2,  OP_OR   = 4'd3,
    OP_XOR   = 4'd4,  OP_MUL  = 4'd5,  OP_MAC  = 4'd6,  OP_SHL  = 4'd7,
    OP_SHR   = 4'd8,  OP_SHRND = 4'd9, OP_ABSD = 4'd10, OP_ADD3 = 4'd11,
    OP_MIN   = 4'd12, OP_MAX  = 4'd13, OP_PASS = 4'd14, OP_ZERO = 4'd15
  } op_e;

  typedef enum logic [SRC_W-1:0] {
    SRC_STRM = 2'd0, SRC_GREG = 2'd1, SRC_NBR = 2'd2, SRC_LOCAL = 2'd3
  } src_e;

  typedef struct packed {
    logic [SH_W-1:0] shamt;
    src_e            src_c;
    src_e            src_b;
    src_e            src_a;
    logic            sgn;
    logic            wide;
    op_e             op;
  } ctrl_t;

  typedef struct packed {
    logic lor_coef;
    logic out_sel;
  } route_t;

  localparam logic [CFG_ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [CFG_ADDR_W-1:0] ADDR_COEF  = 2'd1;
  localparam logic [CFG_ADDR_W-1:0] ADDR_ROUTE = 2'd2;
endpackage

// File: rtl/pcell_cfg_bank.sv
module pcell_cfg_bank
  import pcell_pkg::*;
#(
  parameter int DATA_W = CFG_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_en,
  input  logic [CFG_ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0]     cfg_data,
  input  logic                  cfg_swap,
  output ctrl_t                 act_ctrl,
  output logic [DATA_W-1:0]     act_coef,
  output route_t                act_route,
  output logic                  act_sel
);
  localparam int N_LAYERS = 2;

  logic sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sel_q <= 1'b0;
    else if (cfg_swap) sel_q <= ~sel_q;
  end

  for (genvar l = 0; l < N_LAYERS; l++) begin : g_layer
    localparam logic L_ID = 1'(l);
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] coef_q;
    route_t            route_q;
    logic              wr_here;

    // writes target the layer that is not currently active
    assign wr_here = cfg_en && (sel_q != L_ID);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q  <= '0;
        coef_q  <= '0;
        route_q <= '0;
      end else if (wr_here) begin
        case (cfg_addr)
          ADDR_CTRL:  ctrl_q  <= ctrl_t'(cfg_data[CFG_W-1:0]);
          ADDR_COEF:  coef_q  <= cfg_data;
          ADDR_ROUTE: route_q <= route_t'(cfg_data[1:0]);
          default:    ;
        endcase
      end
    end
  end

  assign act_ctrl  = sel_q ? g_layer[1].ctrl_q  : g_layer[0].ctrl_q;
  assign act_coef  = sel_q ? g_layer[1].coef_q  : g_layer[0].coef_q;
  assign act_route = sel_q ? g_layer[1].route_q : g_layer[0].route_q;
  assign act_sel   = sel_q;
endmodule

// File: rtl/pcell_opsel.sv
module pcell_opsel
  import pcell_pkg::*;
#(
  parameter int DATA_W = CFG_W,
  parameter int NOPS   = N_OPND
) (
  input  logic [DATA_W-1:0] strm_in,
  input  logic [DATA_W-1:0] greg_in,
  input  logic [DATA_W-1:0] nbr_in,
  input  logic [DATA_W-1:0] loc_in,
  input  src_e              sel   [NOPS],
  output logic [DATA_W-1:0] opnd  [NOPS]
);
  for (genvar i = 0; i < NOPS; i++) begin : g_opnd
    always_comb begin
      case (sel[i])
        SRC_STRM: opnd[i] = strm_in;
        SRC_GREG: opnd[i] = greg_in;
        SRC_NBR:  opnd[i] = nbr_in;
        default:  opnd[i] = loc_in;
      endcase
    end
  end
endmodule

// File: rtl/pcell_alu.sv
module pcell_alu
  import pcell_pkg::*;
#(
  parameter int DATA_W = CFG_W
) (
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] c,
  output logic [DATA_W-1:0] res
);
  localparam int NW = DATA_W / 2;
  localparam int EW = DATA_W + 2;
  localparam logic signed [EW-1:0] ONE = EW'(1);

  function automatic logic signed [EW-1:0] extend(input logic [DATA_W-1:0] x,
                                                  input logic wide, input logic sgn);
    logic fill;
    if (wide) begin
      fill = sgn & x[DATA_W-1];
      return {{(EW-DATA_W){fill}}, x};
    end
    fill = sgn & x[NW-1];
    return {{(EW-NW){fill}}, x[NW-1:0]};
  endfunction

  logic signed [EW-1:0] ea, eb, ec, diff, mul_lo, half, rnd_sum, raw;
  logic unused_raw_hi;

  always_comb begin
    ea      = extend(a, ctrl.wide, ctrl.sgn);
    eb      = extend(b, ctrl.wide, ctrl.sgn);
    ec      = extend(c, ctrl.wide, ctrl.sgn);
    diff    = ea - eb;
    mul_lo  = ea * eb;
    half    = (ctrl.shamt == '0) ? '0 : (ONE << (ctrl.shamt - 4'd1));
    rnd_sum = ea + half;
    case (ctrl.op)
      OP_ADD:   raw = ea + eb;
      OP_SUB:   raw = diff;
      OP_AND:   raw = ea & eb;
      OP_OR:    raw = ea | eb;
      OP_XOR:   raw = ea ^ eb;
      OP_MUL:   raw = mul_lo;
      OP_MAC:   raw = mul_lo + ec;
      OP_SHL:   raw = ea <<< ctrl.shamt;
      OP_SHR:   raw = ea >>> ctrl.shamt;
      OP_SHRND: raw = rnd_sum >>> ctrl.shamt;
      OP_ABSD:  raw = diff[EW-1] ? -diff : diff;
      OP_ADD3:  raw = ea + eb + ec;
      OP_MIN:   raw = (ea < eb) ? ea : eb;
      OP_MAX:   raw = (ea < eb) ? eb : ea;
      OP_PASS:  raw = ea;
      default:  raw = '0;
    endcase
    if (ctrl.wide)
      res = raw[DATA_W-1:0];
    else
      res = {{NW{ctrl.sgn & raw[NW-1]}}, raw[NW-1:0]};
  end

  assign unused_raw_hi = ^raw[EW-1:DATA_W];
endmodule

// File: rtl/pcell_top.sv
module pcell_top
  import pcell_pkg::*;
#(
  parameter int DATA_W = CFG_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  cfg_en,
  input  logic [CFG_ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0]     cfg_data,
  input  logic                  cfg_swap,
  input  logic [DATA_W-1:0]     strm_in,
  input  logic [DATA_W-1:0]     greg_in,
  input  logic [DATA_W-1:0]     nbr_in,
  output logic [DATA_W-1:0]     pe_out,
  output logic [DATA_W-1:0]     lor_out
);
  ctrl_t             act_ctrl;
  route_t            act_route;
  logic [DATA_W-1:0] act_coef;
  logic              act_sel;
  src_e              op_sel [N_OPND];
  logic [DATA_W-1:0] opnd   [N_OPND];
  logic [DATA_W-1:0] alu_res, out_q, lor_q;

  pcell_cfg_bank #(.DATA_W(DATA_W)) i_bank (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .cfg_swap(cfg_swap), .act_ctrl(act_ctrl),
    .act_coef(act_coef), .act_route(act_route), .act_sel(act_sel)
  );

  assign op_sel[0] = act_ctrl.src_a;
  assign op_sel[1] = act_ctrl.src_b;
  assign op_sel[2] = act_ctrl.src_c;

  pcell_opsel #(.DATA_W(DATA_W), .NOPS(N_OPND)) i_opsel (
    .strm_in(strm_in), .greg_in(greg_in), .nbr_in(nbr_in), .loc_in(lor_q),
    .sel(op_sel), .opnd(opnd)
  );

  pcell_alu #(.DATA_W(DATA_W)) i_alu (
    .ctrl(act_ctrl), .a(opnd[0]), .b(opnd[1]), .c(opnd[2]), .res(alu_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      lor_q <= '0;
    end else if (en) begin
      out_q <= act_route.out_sel ? lor_q : alu_res;
      lor_q <= act_route.lor_coef ? act_coef : opnd[0];
    end
  end

  assign pe_out  = out_q;
  assign lor_out = lor_q;
endmodule

// File: rtl/pcell_chk.sv
module pcell_chk
  import pcell_pkg::*;
#(
  parameter int DATA_W = CFG_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              cfg_en,
  input logic              cfg_swap,
  input logic [DATA_W-1:0] pe_out,
  input logic [DATA_W-1:0] lor_out,
  input logic              act_sel,
  input logic [CFG_W-1:0]  act_ctrl_bits,
  input logic [DATA_W-1:0] act_coef,
  input logic              out_sel,
  input logic              lor_coef,
  input logic              wide,
  input logic              sgn
);
  localparam int NW = DATA_W / 2;

  // R4
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(pe_out) && $stable(lor_out)));

  // R3
  swap_toggles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_swap |=> (act_sel != $past(act_sel)));

  // R3
  no_swap_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_swap |=> $stable(act_sel));

  // R2
  shadow_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && !cfg_swap) |=> ($stable(act_ctrl_bits) && $stable(act_coef)));

  // R12
  coef_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && lor_coef) |=> (lor_out == $past(act_coef)));

  // R13
  out_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && out_sel) |=> (pe_out == $past(lor_out)));

  // R11
  narrow_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !out_sel && !wide && sgn) |=> (pe_out[DATA_W-1:NW] == {NW{pe_out[NW-1]}}));

  // R11
  narrow_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !out_sel && !wide && !sgn) |=> (pe_out[DATA_W-1:NW] == '0));
endmodule

bind pcell_top pcell_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cfg_en(cfg_en), .cfg_swap(cfg_swap),
  .pe_out(pe_out), .lor_out(lor_out), .act_sel(act_sel),
  .act_ctrl_bits(act_ctrl), .act_coef(act_coef),
  .out_sel(act_route.out_sel), .lor_coef(act_route.lor_coef),
  .wide(act_ctrl.wide), .sgn(act_ctrl.sgn)
);

// File: tb/test_pcell_top.sv
module test_pcell_top;
  logic        clk = 1'b0;
  logic        rst_n, en, cfg_en, cfg_swap;
  logic [1:0]  cfg_addr;
  logic [15:0] cfg_data, strm_in, greg_in, nbr_in;
  logic [15:0] pe_out, lor_out;

  always #10 clk = ~clk;

  pcell_top i_pcell_top (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_en(cfg_en), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .cfg_swap(cfg_swap), .strm_in(strm_in),
    .greg_in(greg_in), .nbr_in(nbr_in), .pe_out(pe_out), .lor_out(lor_out)
  );

  int    checks = 0, failures = 0;
  string cur_req = "R1";
  bit    cmp_on = 0, timed_out = 0;

  // behavioural reference state
  logic [15:0] m_ctrl [2], m_coef [2];
  logic [1:0]  m_route [2];
  bit          m_sel;
  logic [15:0] m_out, m_lor;

  function automatic longint tb_ext(logic [15:0] x, int w, bit sgn);
    longint m = (longint'(1) << w) - 1;
    longint v = longint'(x) & m;
    if (sgn && v[w-1]) v = v - (longint'(1) << w);
    return v;
  endfunction

  function automatic logic [15:0] ref_calc(logic [15:0] ctl, logic [15:0] ar,
                                           logic [15:0] br, logic [15:0] cr);
    int     op = int'(ctl[3:0]);
    bit     sgn = ctl[5];
    int     w = ctl[4] ? 16 : 8;
    int     sh = int'(ctl[15:12]);
    longint m = (longint'(1) << w) - 1;
    longint a = tb_ext(ar, w, sgn), b = tb_ext(br, w, sgn), c = tb_ext(cr, w, sgn);
    longint r, half;
    half = (sh == 0) ? 0 : (longint'(1) << (sh - 1));
    case (op)
      0: r = a + b;            1: r = a - b;
      2: r = a & b;            3: r = a | b;
      4: r = a ^ b;            5: r = a * b;
      6: r = a * b + c;        7: r = a << sh;
      8: r = a >>> sh;         9: r = (a + half) >>> sh;
      10: r = (a > b) ? a - b : b - a;
      11: r = a + b + c;
      12: r = (a < b) ? a : b; 13: r = (a > b) ? a : b;
      14: r = a;
      default: r = 0;
    endcase
    r = r & m;
    if (sgn && r[w-1]) r = r | ~m;
    return r[15:0];
  endfunction

  function automatic logic [15:0] pick_src(logic [1:0] s);
    case (s)
      2'd0: return strm_in;
      2'd1: return greg_in;
      2'd2: return nbr_in;
      default: return m_lor;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl[0] = '0; m_ctrl[1] = '0; m_coef[0] = '0; m_coef[1] = '0;
      m_route[0] = '0; m_route[1] = '0; m_sel = 0; m_out = '0; m_lor = '0;
    end else begin
      logic [15:0] c, a, b, cc, nout, nlor;
      c = m_ctrl[m_sel];
      a = pick_src(c[7:6]); b = pick_src(c[9:8]); cc = pick_src(c[11:10]);
      nout = m_out; nlor = m_lor;
      if (en) begin
        nout = m_route[m_sel][0] ? m_lor : ref_calc(c, a, b, cc);
        nlor = m_route[m_sel][1] ? m_coef[m_sel] : a;
      end
      m_out = nout; m_lor = nlor;
      if (cfg_en) begin
        case (cfg_addr)
          2'd0: m_ctrl[!m_sel] = cfg_data;
          2'd1: m_coef[!m_sel] = cfg_data;
          2'd2: m_route[!m_sel] = cfg_data[1:0];
          default: ;
        endcase
      end
      if (cfg_swap) m_sel = !m_sel;
    end
  end

  task automatic check_eq(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      check_eq({cur_req, " pe_out"}, pe_out, m_out);
      check_eq({cur_req, " lor_out"}, lor_out, m_lor);
    end
  end

  function automatic logic [15:0] pick_val();
    case ($urandom % 8)
      0: return 16'h0000; 1: return 16'hFFFF; 2: return 16'h8000;
      3: return 16'h7FFF; 4: return 16'h0080; 5: return 16'h007F;
      default: return 16'($urandom);
    endcase
  endfunction

  task automatic tick(bit e, bit ce, logic [1:0] ad, logic [15:0] d, bit sw);
    @(negedge clk);
    en = e; cfg_en = ce; cfg_addr = ad; cfg_data = d; cfg_swap = sw;
    strm_in = pick_val(); greg_in = pick_val(); nbr_in = pick_val();
  endtask

  task automatic run_cycles(int n, int pct);
    repeat (n) tick(($urandom % 100) < pct, 0, 2'd0, 16'h0, 0);
  endtask

  // last write shares its cycle with the swap (R3)
  task automatic load_layer(logic [15:0] ctl, logic [15:0] coef, logic [1:0] rt);
    tick(1, 1, 2'd0, ctl, 0);
    tick(1, 1, 2'd1, coef, 0);
    tick(1, 1, 2'd2, {14'h0, rt}, 1);
  endtask

  function automatic logic [15:0] mk_ctrl(int op, bit wd, bit sg, int sa, int sb,
                                          int sc, int sh);
    return {4'(sh), 2'(sc), 2'(sb), 2'(sa), sg, wd, 4'(op)};
  endfunction

  function automatic string tag_for(int op, bit wd);
    if (!wd) return "R11";
    case (op)
      5, 6: return "R7";
      7, 8: return "R8";
      9: return "R9";
      10, 12, 13: return "R10";
      14: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    rst_n = 0; en = 0; cfg_en = 0; cfg_swap = 0; cfg_addr = '0; cfg_data = '0;
    strm_in = '0; greg_in = '0; nbr_in = '0;
    fork
      begin : main_seq
        repeat (3) @(negedge clk);
        check_eq("R1 reset pe_out", pe_out, 16'h0);
        check_eq("R1 reset lor_out", lor_out, 16'h0);
        rst_n = 1;
        cmp_on = 1;
        cur_req = "R1";
        run_cycles(6, 100);
        for (int op = 0; op < 16; op++)
          for (int md = 0; md < 4; md++) begin
            load_layer(mk_ctrl(op, md[1], md[0], 0, 1, 2, $urandom % 16), 16'h0, 2'b00);
            cur_req = tag_for(op, md[1]);
            run_cycles(10, 90);
          end
        for (int sh = 0; sh < 16; sh++)
          for (int md = 0; md < 4; md++) begin
            cur_req = "R9";
            load_layer(mk_ctrl(9, md[1], md[0], 2, 0, 0, sh), 16'h0, 2'b00);
            run_cycles(6, 100);
            cur_req = "R8";
            load_layer(mk_ctrl(8, md[1], md[0], 1, 0, 0, sh), 16'h0, 2'b00);
            run_cycles(4, 100);
          end
        cur_req = "R5";
        for (int s = 0; s < 64; s++) begin
          load_layer(mk_ctrl(11, 1, 0, s % 4, (s / 4) % 4, s / 16, 0), 16'h0, 2'b00);
          run_cycles(4, 100);
        end
        cur_req = "R12";
        load_layer(mk_ctrl(14, 1, 0, 3, 0, 0, 0), 16'hBEEF, 2'b10);
        run_cycles(8, 80);
        load_layer(mk_ctrl(0, 1, 1, 0, 3, 0, 0), 16'h8001, 2'b10);
        run_cycles(8, 100);
        load_layer(mk_ctrl(14, 1, 0, 0, 0, 0, 0), 16'h1234, 2'b00);
        run_cycles(8, 100);
        cur_req = "R13";
        load_layer(mk_ctrl(14, 1, 0, 1, 0, 0, 0), 16'h0, 2'b01);
        run_cycles(10, 100);
        load_layer(mk_ctrl(1, 0, 1, 0, 2, 0, 0), 16'h5A5A, 2'b11);
        run_cycles(10, 80);
        cur_req = "R2";
        load_layer(mk_ctrl(0, 1, 0, 0, 1, 0, 0), 16'h0, 2'b00);
        for (int i = 0; i < 8; i++) tick(1, 1, 2'(i % 4), 16'($urandom), 0);
        run_cycles(4, 100);
        cur_req = "R3";
        tick(1, 0, 2'd0, 16'h0, 1);
        run_cycles(3, 100);
        for (int i = 0; i < 6; i++) tick(1, i[0], 2'd0, mk_ctrl(i + 5, 1, i[1], 0, 1, 2, 3), 1);
        run_cycles(4, 100);
        cur_req = "R4";
        run_cycles(10, 0);
        run_cycles(30, 50);
        for (int i = 0; i < 4; i++) tick(0, 1, 2'(i), 16'($urandom), i[0]);
        run_cycles(6, 0);
        @(negedge clk);
      end
      begin : watchdog
        repeat (150000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule